// File: doc/BRIEF.md
# Triple-Sample Bit Recovery Unit

This unit turns an asynchronous, non-return-to-zero serial line into a stream of recovered bits. One bit period lasts exactly as many system-clock cycles as the programmed divisor (3 to 15). Within each period the line is sampled three times, at positions that follow from the divisor. The recovered level is the majority of the three samples.

Each decision also reports a noise event when the middle sample stands alone. When the sender runs slightly fast or slow, the phase of the sampling grid is moved by one cycle, earlier or later, so the grid keeps up with the line. A downstream destuffer or framer takes the one-cycle strobe and the bit value.

Top module: `tri_sample_rx`

## Requirements
- R1: While rst_ni is low, bit_valid_o, bit_o and noise_o are 0. After release, the phase counter starts at cycle 0, so the first strobe appears in cycle d, where d is the divisor and cycle 0 is the first cycle after release.
- R2: Without resynchronisation, a bit period lasts exactly d cycles. bit_valid_o is high for one cycle only, in the cycle after the third sample of a period.
- R3: For an odd divisor, the samples are taken at offsets 0, (d-1)/2 and d-1 of the period.
- R4: For an even divisor, the samples are taken at offsets 1, d/2 and d-1 of the period.
- R5: bit_o, valid with the strobe, equals the majority of the three samples. A 1 on the line gives a 1 on bit_o.
- R6: noise_o pulses together with the strobe when the first and third samples agree and the middle sample differs from them. It is 0 in every other cycle.
- R7: When samples 1 and 2 agree and sample 3 differs, the next period starts one cycle early, so its origin is one cycle before the end of the current period. Its first sample is taken at the first counted cycle at or after its nominal offset.
- R8: When samples 2 and 3 agree and sample 1 differs, one idle cycle is inserted before the next period starts.
- R9: div_i is taken only in cycle 0 after reset and in the last cycle of each period, and it applies to the following period. Values below 3 act as 3.
- R10: rx_i passes through a two-flop synchronizer, so a sample taken in cycle t sees the level that rx_i had in cycle t-2.
- R11: bit_o holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line |
| div_i | input | 4 | Bit period in clock cycles (3..15) |
| bit_valid_o | output | 1 | One-cycle strobe for a new recovered bit |
| bit_o | output | 1 | Recovered bit value, held between strobes |
| noise_o | output | 1 | Noise pulse, aligned with the strobe |

## Verification
Any fault in the phase counter, in the slot positions or in the divisor latch moves the strobe cycle. That error shows on bit_valid_o within one bit period, at most 16 cycles, and it keeps growing as later periods slip. A wrong sample slot or a wrong majority shows first as a wrong bit_o at a strobe. A wrong resynchronisation choice shifts every later strobe by one cycle. The bench therefore compares every output in every cycle against a period-by-period model, for each divisor and for line patterns that are clean, glitched, fast, slow, or have a divisor change in the middle of the run.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int DIV_MIN = 3;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_EARLY = 2'd1,
    ADJ_LATE  = 2'd2
  } phase_adj_e;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsr_slots.sv
module tsr_slots #(
  parameter int DIV_W = 4
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] first_o,
  output logic [DIV_W-1:0] mid_o,
  output logic [DIV_W-1:0] last_o
);
  logic [DIV_W-1:0] base, step;

  always_comb begin
    base    = div_i[0] ? '0 : DIV_W'(1);
    step    = (div_i - DIV_W'(1) - base) >> 1;
    first_o = base;
    mid_o   = base + step;
    last_o  = base + (step << 1);
  end
endmodule

// File: rtl/tsr_vote.sv
module tsr_vote
  import tsr_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       c_i,
  output logic       maj_o,
  output logic       noise_o,
  output phase_adj_e adj_o
);
  always_comb begin
    maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    noise_o = (a_i == c_i) && (b_i != a_i);
    if ((a_i == b_i) && (c_i != b_i))      adj_o = ADJ_EARLY;
    else if ((b_i == c_i) && (a_i != b_i)) adj_o = ADJ_LATE;
    else                                   adj_o = ADJ_NONE;
  end
endmodule

// File: rtl/tri_sample_rx.sv
module tri_sample_rx
  import tsr_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_valid_o,
  output logic             bit_o,
  output logic             noise_o
);
  localparam logic [DIV_W-1:0] DivFloor = DIV_W'(DIV_MIN);

  logic             rx_s;
  logic             init_q, stall_q, first_q, s1_q, s2_q;
  logic             valid_q, bit_q, noise_q;
  logic [DIV_W-1:0] div_q, div_lim, d_use, cnt_q;
  logic [DIV_W-1:0] p1, p2, p3;
  logic             end_w, maj_w, noise_w;
  phase_adj_e       adj_w;

  tsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  assign div_lim = (div_i < DivFloor) ? DivFloor : div_i;
  assign d_use   = init_q ? div_lim : div_q;

  tsr_slots #(.DIV_W(DIV_W)) u_slots (
    .div_i  (d_use),
    .first_o(p1),
    .mid_o  (p2),
    .last_o (p3)
  );

  tsr_vote u_vote (
    .a_i    (s1_q),
    .b_i    (s2_q),
    .c_i    (rx_s),
    .maj_o  (maj_w),
    .noise_o(noise_w),
    .adj_o  (adj_w)
  );

  assign end_w = !stall_q && (cnt_q == p3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      div_q   <= DivFloor;
      cnt_q   <= '0;
      stall_q <= 1'b0;
      first_q <= 1'b1;
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      noise_q <= 1'b0;
    end else begin
      init_q  <= 1'b0;
      valid_q <= 1'b0;
      noise_q <= 1'b0;
      if (init_q || end_w) div_q <= div_lim;
      if (stall_q) begin
        stall_q <= 1'b0;  // idle cycle from a late correction
      end else if (end_w) begin
        valid_q <= 1'b1;
        bit_q   <= maj_w;
        noise_q <= noise_w;
        first_q <= 1'b1;
        unique case (adj_w)
          ADJ_EARLY: cnt_q <= DIV_W'(1);
          ADJ_LATE: begin
            cnt_q   <= '0;
            stall_q <= 1'b1;
          end
          default: cnt_q <= '0;
        endcase
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
        // first slot may be skipped by an early start: take it at the first counted cycle
        if (first_q && (cnt_q >= p1)) begin
          s1_q    <= rx_s;
          first_q <= 1'b0;
        end
        if (cnt_q == p2) s2_q <= rx_s;
      end
    end
  end

  assign bit_valid_o = valid_q;
  assign bit_o       = bit_q;
  assign noise_o     = noise_q;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_valid_o,
  input logic bit_o,
  input logic noise_o
);
  logic [4:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= '0;
    else if (bit_valid_o)  gap_q <= 5'd1;
    else if (gap_q != '1)  gap_q <= gap_q + 5'd1;
  end

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  assert_strobe_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (gap_q >= 5'd2) && (gap_q <= 5'd16));

  assert_noise_with_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_o |-> bit_valid_o);

  assert_bit_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> $stable(bit_o));
endmodule

bind tri_sample_rx tsr_checker u_tsr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_valid_o(bit_valid_o),
  .bit_o      (bit_o),
  .noise_o    (noise_o)
);

// File: tb/tb_tri_sample_rx.sv
module tb_tri_sample_rx;
  localparam int CLK_PERIOD = 10;
  localparam int N = 400;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b0;
  logic [3:0] div_i = 4'd3;
  logic       bit_valid_o, bit_o, noise_o;

  int compared = 0;
  int mismatched = 0;

  int line_a [N];
  int div_a  [N];
  bit exp_v  [N+1];
  bit exp_b  [N+1];
  bit exp_n  [N+1];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tri_sample_rx dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .div_i      (div_i),
    .bit_valid_o(bit_valid_o),
    .bit_o      (bit_o),
    .noise_o    (noise_o)
  );

  function automatic int seen(input int t);
    if (t < 0 || t >= N) return 0;
    return line_a[t];
  endfunction

  function automatic int clampd(input int d);
    return (d < 3) ? 3 : d;
  endfunction

  function automatic int hb(input int k, input int s);
    int h = (k * 1103515245 + s * 12345 + 7) ^ (k >>> 3);
    return (h >>> 9) & 1;
  endfunction

  task automatic check(input string req, input int act, input int expv, input int c);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, c, act, expv);
    end
  endtask

  // kind 0: clean, 1: glitches
  task automatic gen(input int d0, input int d1, input int blen, input int kind, input int seed);
    for (int c = 0; c < N; c++) begin
      int k = (c + 2 + (seed % blen)) / blen;
      int v = hb(k, seed);
      if (kind == 1 && hb(c, seed + 99) == 1 && hb(c + 5, seed + 3) == 1 && hb(c, seed + 41) == 1)
        v = 1 - v;
      line_a[c] = v;
      div_a[c]  = (c < N/2) ? d0 : d1;
    end
  endtask

  // period-by-period expectation from the requirements
  task automatic model();
    int o, f, d, t1, t2, t3, a, b, e, p1, p2;
    for (int c = 0; c <= N; c++) begin
      exp_v[c] = 1'b0; exp_b[c] = 1'b0; exp_n[c] = 1'b0;
    end
    o = 0; f = 0; d = clampd(div_a[0]);
    while (o + d - 1 < N) begin
      if (d % 2 == 1) begin p1 = 0; p2 = (d - 1) / 2; end
      else            begin p1 = 1; p2 = d / 2; end
      t1 = (o + p1 < f) ? f : o + p1;
      t2 = o + p2;
      t3 = o + d - 1;
      a = seen(t1 - 2); b = seen(t2 - 2); e = seen(t3 - 2);
      exp_v[o + d] = 1'b1;
      exp_b[o + d] = ((a + b + e) >= 2);
      exp_n[o + d] = (a == e) && (b != a);
      begin
        int nd = clampd(div_a[t3]);
        if (a == b && e != b)      begin f = o + d;     o = o + d - 1; end
        else if (b == e && a != b) begin o = o + d + 1; f = o;         end
        else                       begin o = o + d;     f = o;         end
        d = nd;
      end
    end
  endtask

  task automatic run(input string tag);
    bit held = 1'b0;
    model();
    rst_ni = 1'b0;
    rx_i   = 1'b0;
    div_i  = div_a[0][3:0];
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 valid in reset", int'(bit_valid_o), 0, -1);
    check("R1 bit in reset", int'(bit_o), 0, -1);
    check("R1 noise in reset", int'(noise_o), 0, -1);
    rst_ni = 1'b1;
    for (int c = 0; c <= N; c++) begin
      rx_i  = seen(c)[0];
      div_i = (c < N) ? div_a[c][3:0] : div_a[N-1][3:0];
      check(tag, int'(bit_valid_o), int'(exp_v[c]), c);
      if (exp_v[c]) begin
        held = exp_b[c];
        check(tag, int'(noise_o), int'(exp_n[c]), c);
      end else begin
        check("R6 noise only with strobe", int'(noise_o), 0, c);
      end
      check("R11 bit value", int'(bit_o), int'(held), c);
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int d = 3; d <= 15; d++) begin
      gen(d, d, d, 0, d * 17 + 1);
      run((d % 2 == 1) ? "R2 R3 R5 R10 clean odd" : "R2 R4 R5 R10 clean even");
      gen(d, d, d, 1, d * 29 + 3);
      run("R5 R6 glitched");
      if (d > 3) begin
        gen(d, d, d - 1, 0, d * 7 + 5);
        run("R7 fast sender");
      end
      gen(d, d, d + 1, 0, d * 11 + 2);
      run("R8 slow sender");
    end
    gen(5, 12, 5, 0, 91);
    run("R9 divisor change");
    gen(0, 9, 3, 0, 57);
    run("R9 divisor clamp");
    gen(14, 4, 14, 1, 33);
    run("R9 R1 change with glitches");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule